// File: doc/BRIEF.md
# Seeded LFSR Input Sequence Generator for Built-In Functional Two-Pattern Test

This block produces a fixed-length series of input vectors for a sequential circuit under on-chip test. A seed is loaded, and from the next cycle onward one vector is presented per clock. Each vector comes from a Fibonacci linear feedback shift register. Its upper bits give the raw values for the circuit inputs. Its lower bits are used only to alter those raw values, so that the random stream does not keep pushing the circuit back into the same few states. The circuit starts in a known state, so every state it passes through under this stream is one it can reach in normal operation. Any two consecutive vectors, together with the state reached before the first of them, then form a usable two-pattern test.

Every run is exactly SEQ_LEN vectors long. Runs differ only in their seed. A seed of all zeros would lock the register, so it is replaced by a fixed nonzero constant. The block reports the index of the vector currently presented and a flag that rises once the last vector has been shown. After that flag rises, the register and the outputs hold until the next seed load.

Top module: `pi_seq_gen`

## Requirements
- R1: After reset, seq_done is 1, seq_idx is 0, and the register holds SEED_FALLBACK (default 7'h41), so pi_vec shows that state's modified vector (4'h9 with default parameters).
- R2: A load_seed pulse sampled at a rising edge makes the next cycle present a(0) built from the seed, with seq_idx = 0 and seq_done = 0.
- R3: A loaded seed of all zeros is replaced by SEED_FALLBACK, so the run behaves exactly like a run seeded with 7'h41.
- R4: While a run is active and not at its last vector, each clock shifts the register one place toward the MSB, enters the XOR of the bits selected by TAPS (default 7'b1100000) at bit 0, and increments seq_idx by one.
- R5: Register bits [MOD+N_PI-1:MOD] are the raw inputs and bits [MOD-1:0] are the modifier bits. Output pi_vec[i] is raw bit i XOR the AND of the modifier bits selected by field MOD_MASK[i*MOD +: MOD]. The default masks for inputs 0..3 are 3'b001, 3'b011, 3'b110 and 3'b111.
- R6: A run presents exactly SEQ_LEN vectors, a(0) to a(SEQ_LEN-1), one per cycle. a(SEQ_LEN-1) is shown with seq_idx = SEQ_LEN-1 for one cycle, and seq_done is 1 in the following cycle.
- R7: While seq_done is 1 and no load arrives, pi_vec and seq_idx stay unchanged.
- R8: load_seed takes priority over stepping at any point of a run, including the cycle that shows a(SEQ_LEN-1). The next cycle shows the new a(0), and seq_done stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock; one vector per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_seed | input | 1 | Starts a new run from seed_in |
| seed_in | input | N_PI+MOD | Seed for the shift register |
| pi_vec | output | N_PI | Current modified input vector a(u) |
| seq_idx | output | clog2(SEQ_LEN) | Index u of the vector shown |
| seq_done | output | 1 | High once the last vector of the run has been shown |

## Verification
Two functions can fall in the same cycle: the run-end step, which raises seq_done after a(SEQ_LEN-1), and a seed reload. The bench provokes this by asserting load_seed exactly in the cycle that shows index SEQ_LEN-1. It then expects the new seed's a(0) with seq_done still low, not a finished run. A reload in the middle of a run and a reload during the hold state are also compared against an independent model of the register, built from the tap and mask encodings given in the requirements.

// File: rtl/pi_seq_pkg.sv
package pi_seq_pkg;

   typedef enum logic {
      RUN_IDLE = 1'b0,
      RUN_BUSY = 1'b1
   } run_state_e;

   localparam int unsigned MAX_W = 64;

   function automatic logic masked_parity(input logic [MAX_W-1:0] v,
                                          input logic [MAX_W-1:0] m);
      return ^(v & m);
   endfunction

   function automatic logic masked_all(input logic [MAX_W-1:0] v,
                                       input logic [MAX_W-1:0] m);
      return &(v | ~m);
   endfunction

endpackage

// File: rtl/pi_seq_lfsr.sv
module pi_seq_lfsr
   import pi_seq_pkg::*;
#(
   parameter int unsigned W        = 7,
   parameter logic [W-1:0] TAPS     = 7'b1100000,
   parameter logic [W-1:0] FALLBACK = 7'h41
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] seed,
   input  logic         adv,
   output logic [W-1:0] state
);

   logic [W-1:0] st_q;
   logic [W-1:0] st_next;
   logic [W-1:0] seed_fix;
   logic         fb;

   assign fb       = masked_parity(MAX_W'(st_q), MAX_W'(TAPS));
   assign seed_fix = (seed == '0) ? FALLBACK : seed;

   generate
      if (W == 1) begin : g_one
         assign st_next = fb;
      end else begin : g_wide
         assign st_next = {st_q[W-2:0], fb};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= FALLBACK;
      end else if (load) begin
         st_q <= seed_fix;
      end else if (adv) begin
         st_q <= st_next;
      end
   end

   assign state = st_q;

endmodule

// File: rtl/pi_seq_mod.sv
module pi_seq_mod
   import pi_seq_pkg::*;
#(
   parameter int unsigned         N_PI     = 4,
   parameter int unsigned         MOD      = 3,
   parameter logic [N_PI*MOD-1:0] MOD_MASK = 12'b111_110_011_001
) (
   input  logic [N_PI-1:0] raw,
   input  logic [MOD-1:0]  modb,
   output logic [N_PI-1:0] pi
);

   generate
      for (genvar i = 0; i < N_PI; i++) begin : g_pi
         localparam logic [MOD-1:0] SEL = MOD_MASK[i*MOD +: MOD];
         if (SEL == '0) begin : g_bad
            $error("pi_seq_mod: mask field for an input is all zeros");
         end
         logic hit;
         assign hit   = masked_all(MAX_W'(modb), MAX_W'(SEL));
         assign pi[i] = raw[i] ^ hit;
      end
   endgenerate

endmodule

// File: rtl/pi_seq_ctl.sv
module pi_seq_ctl
   import pi_seq_pkg::*;
#(
   parameter int unsigned SEQ_LEN = 16,
   parameter int unsigned IDXW    = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   output logic            adv,
   output logic [IDXW-1:0] idx,
   output logic            done
);

   localparam logic [IDXW-1:0] LAST = IDXW'(SEQ_LEN - 1);

   run_state_e      st_q;
   logic [IDXW-1:0] idx_q;
   logic            at_last;

   assign at_last = (idx_q == LAST);
   assign adv     = (st_q == RUN_BUSY) && !at_last && !load;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= RUN_IDLE;
         idx_q <= '0;
      end else if (load) begin
         st_q  <= RUN_BUSY;
         idx_q <= '0;
      end else if (st_q == RUN_BUSY) begin
         if (at_last) begin
            st_q <= RUN_IDLE;
         end else begin
            idx_q <= idx_q + IDXW'(1);
         end
      end
   end

   assign idx  = idx_q;
   assign done = (st_q == RUN_IDLE);

endmodule

// File: rtl/pi_seq_gen.sv
module pi_seq_gen
   import pi_seq_pkg::*;
#(
   parameter int unsigned                 N_PI          = 4,
   parameter int unsigned                 MOD           = 3,
   parameter int unsigned                 SEQ_LEN       = 16,
   parameter logic [N_PI+MOD-1:0]         TAPS          = 7'b1100000,
   parameter logic [N_PI+MOD-1:0]         SEED_FALLBACK = 7'h41,
   parameter logic [N_PI*MOD-1:0]         MOD_MASK      = 12'b111_110_011_001,
   localparam int unsigned                W             = N_PI + MOD,
   localparam int unsigned                IDXW          = (SEQ_LEN > 2) ? $clog2(SEQ_LEN) : 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load_seed,
   input  logic [W-1:0]    seed_in,
   output logic [N_PI-1:0] pi_vec,
   output logic [IDXW-1:0] seq_idx,
   output logic            seq_done
);

   generate
      if (N_PI < 1)            begin : g_e0 $error("N_PI must be at least 1"); end
      if (MOD < 1)             begin : g_e1 $error("MOD must be at least 1"); end
      if (SEQ_LEN < 2)         begin : g_e2 $error("SEQ_LEN must be at least 2"); end
      if (W > MAX_W)           begin : g_e3 $error("register wider than MAX_W"); end
      if (TAPS[W-1] != 1'b1)   begin : g_e4 $error("TAPS must include the top bit"); end
      if (SEED_FALLBACK == '0) begin : g_e5 $error("SEED_FALLBACK must be nonzero"); end
   endgenerate

   logic         adv;
   logic [W-1:0] lfsr_q;

   pi_seq_ctl #(
      .SEQ_LEN (SEQ_LEN),
      .IDXW    (IDXW)
   ) ctl_i (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (load_seed),
      .adv   (adv),
      .idx   (seq_idx),
      .done  (seq_done)
   );

   pi_seq_lfsr #(
      .W        (W),
      .TAPS     (TAPS),
      .FALLBACK (SEED_FALLBACK)
   ) lfsr_i (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (load_seed),
      .seed  (seed_in),
      .adv   (adv),
      .state (lfsr_q)
   );

   pi_seq_mod #(
      .N_PI     (N_PI),
      .MOD      (MOD),
      .MOD_MASK (MOD_MASK)
   ) mod_i (
      .raw  (lfsr_q[W-1:MOD]),
      .modb (lfsr_q[MOD-1:0]),
      .pi   (pi_vec)
   );

endmodule

// File: rtl/pi_seq_gen_chk.sv
module pi_seq_gen_chk #(
   parameter int unsigned  W       = 7,
   parameter int unsigned  N_PI    = 4,
   parameter int unsigned  SEQ_LEN = 16,
   parameter int unsigned  IDXW    = 4,
   parameter logic [W-1:0] TAPS    = 7'b1100000
) (
   input logic            clk,
   input logic            rst_n,
   input logic            load_seed,
   input logic [N_PI-1:0] pi_vec,
   input logic [IDXW-1:0] seq_idx,
   input logic            seq_done,
   input logic [W-1:0]    lfsr_q
);

   localparam logic [IDXW-1:0] LAST = IDXW'(SEQ_LEN - 1);

   // R1
   a_r1_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (seq_done && seq_idx == '0));

   a_r2_load_restart: assert property (@(posedge clk) disable iff (!rst_n)
      load_seed |=> (seq_idx == '0 && !seq_done));

   a_r3_state_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      !$isunknown(lfsr_q) |-> (lfsr_q != '0));

   a_r4_shift_step: assert property (@(posedge clk) disable iff (!rst_n)
      (!seq_done && seq_idx != LAST && !load_seed) |=>
         (lfsr_q == {$past(lfsr_q[W-2:0]), ^($past(lfsr_q) & TAPS)}));

   a_r4_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
      (!seq_done && seq_idx != LAST && !load_seed) |=>
         (seq_idx == $past(seq_idx) + IDXW'(1)));

   a_r6_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
      (!seq_done && seq_idx == LAST && !load_seed) |=> seq_done);

   a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_done && !load_seed) |=> (seq_done && $stable(pi_vec) && $stable(seq_idx)));

endmodule

bind pi_seq_gen pi_seq_gen_chk #(
   .W       (W),
   .N_PI    (N_PI),
   .SEQ_LEN (SEQ_LEN),
   .IDXW    (IDXW),
   .TAPS    (TAPS)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .load_seed (load_seed),
   .pi_vec    (pi_vec),
   .seq_idx   (seq_idx),
   .seq_done  (seq_done),
   .lfsr_q    (lfsr_q)
);

// File: tb/pi_seq_gen_tb.sv
module pi_seq_gen_tb_top;

   localparam int unsigned N_PI = 4;
   localparam int unsigned MOD  = 3;
   localparam int unsigned W    = 7;
   localparam int unsigned L    = 16;
   localparam logic [6:0]  TAP  = 7'b1100000;
   localparam logic [6:0]  FB   = 7'h41;
   localparam logic [2:0]  MSK [0:3] = '{3'b001, 3'b011, 3'b110, 3'b111};

   // {seed, expected a(0)}
   localparam logic [10:0] TBL [0:3] = '{
      {7'h7F, 4'h0},
      {7'h01, 4'h1},
      {7'h2C, 4'h5},
      {7'h00, 4'h9}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       load_seed = 1'b0;
   logic [6:0] seed_in = '0;
   logic [3:0] pi_vec;
   logic [3:0] seq_idx;
   logic       seq_done;

   int checks = 0;
   int fails  = 0;
   bit ended  = 0;

   always #10 clk = ~clk;

   pi_seq_gen dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_seed (load_seed),
      .seed_in   (seed_in),
      .pi_vec    (pi_vec),
      .seq_idx   (seq_idx),
      .seq_done  (seq_done)
   );

   function automatic logic [6:0] m_step(input logic [6:0] s);
      return {s[5:0], ^(s & TAP)};
   endfunction

   function automatic logic [3:0] m_vec(input logic [6:0] s);
      logic [3:0] v;
      for (int i = 0; i < 4; i++) begin
         logic a;
         a = 1'b1;
         for (int b = 0; b < 3; b++) if (MSK[i][b]) a = a & s[b];
         v[i] = s[3+i] ^ a;
      end
      return v;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic finish_up();
      if (!ended) begin
         ended = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   endtask

   // load at current negedge; returns at the negedge showing a(0)
   task automatic do_load(input logic [6:0] s);
      load_seed = 1'b1;
      seed_in   = s;
      @(negedge clk);
      load_seed = 1'b0;
   endtask

   // walk from a(0) up to showing a(last_u), checking each; ends at that negedge
   task automatic walk(input string req, input logic [6:0] s0, input int last_u);
      logic [6:0] s;
      s = (s0 == 7'h00) ? FB : s0;
      for (int u = 0; u <= last_u; u++) begin
         chk({req, " vec"}, 32'(pi_vec), 32'(m_vec(s)));
         chk({req, " idx"}, 32'(seq_idx), u);
         chk({req, " done"}, 32'(seq_done), 0);
         if (u != last_u) begin
            s = m_step(s);
            @(negedge clk);
         end
      end
   endtask

   initial begin
      for (int c = 0; c < 100000; c++) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      finish_up();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk("R1 done", 32'(seq_done), 1);
      chk("R1 idx", 32'(seq_idx), 0);
      chk("R1 vec", 32'(pi_vec), 32'(4'h9));

      // table walk: R2 first vector, R5 modification, R4 stepping, R6 length, R3 zero seed
      for (int k = 0; k < 4; k++) begin
         logic [6:0] sd;
         logic [3:0] e0;
         logic [3:0] last_v;
         sd = TBL[k][10:4];
         e0 = TBL[k][3:0];
         do_load(sd);
         chk("R2 a0 table", 32'(pi_vec), 32'(e0));
         chk("R5 model a0", 32'(m_vec((sd == 0) ? FB : sd)), 32'(e0));
         walk((sd == 0) ? "R3" : "R4", sd, L - 1);
         last_v = pi_vec;
         @(negedge clk);
         chk("R6 done after last", 32'(seq_done), 1);
         // R7: hold for several cycles
         for (int h = 0; h < 3; h++) begin
            @(negedge clk);
            chk("R7 hold vec", 32'(pi_vec), 32'(last_v));
            chk("R7 hold idx", 32'(seq_idx), L - 1);
            chk("R7 hold done", 32'(seq_done), 1);
         end
      end

      // R8: load in the cycle showing a(L-1)
      do_load(7'h2C);
      walk("R8 pre", 7'h2C, L - 1);
      do_load(7'h01);
      chk("R8 restart done", 32'(seq_done), 0);
      walk("R8 new run", 7'h01, 5);

      // R8: load mid-run, then full run to end
      do_load(7'h7F);
      walk("R8 mid", 7'h7F, L - 1);
      @(negedge clk);
      chk("R6 done mid-load run", 32'(seq_done), 1);

      // R2: load during hold restarts; same seed repeats
      do_load(7'h7F);
      walk("R2 repeat", 7'h7F, 3);

      // R1: reset mid-run returns to idle
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 reset again done", 32'(seq_done), 1);
      chk("R1 reset again vec", 32'(pi_vec), 32'(4'h9));

      finish_up();
   end

endmodule